// File: doc/BRIEF.md
# Four-Phase Handshake Protocol Monitor

This block is a passive checker that sits beside a single-word buffer. The buffer has a write port, where a producer presents data with a request and the buffer answers with an acknowledge. It also has a read port, where the buffer presents data with a request and a consumer answers with an acknowledge. Both ports use a return-to-zero (four-phase) handshake. The monitor only observes. It samples all eight inputs on every rising clock edge and finds edges by comparing each sample with the one from the previous edge. It drives nothing back into the buffer.

Each detected violation sets its own bit in a sticky error vector, and only reset clears that vector. The monitor checks four ordering rules on each port, that writes and reads take turns, and that each word read out equals the word most recently accepted. For the last check it keeps a shadow copy of the accepted word.

Top module: `hs_monitor`

## Requirements
- R1: A request that goes high while the previously sampled acknowledge of the same port is high sets the request-rise bit of that port (bit 0 for the write port, bit 4 for the read port).
- R2: A request that goes low while the previously sampled acknowledge of the same port is low sets the request-fall bit of that port (bit 1 for the write port, bit 5 for the read port).
- R3: An acknowledge that goes high while the previously sampled request of the same port is low sets the acknowledge-rise bit of that port (bit 2 for the write port, bit 6 for the read port).
- R4: An acknowledge that goes low while the previously sampled request of the same port is high sets the acknowledge-fall bit of that port (bit 3 for the write port, bit 7 for the read port).
- R5: The two ports are checked separately. A violation on one port never sets bits 0-3 or 4-7 of the other port.
- R6: Bit 8 (overflow) is set when `in_ack` rises while a word is held, meaning an earlier `in_ack` rise has had no `out_ack` rise after it.
- R7: Bit 9 (underflow) is set when `out_ack` rises while no word is held, which includes the case where no `in_ack` rise has occurred since reset. When both acknowledges rise in the same cycle, the read is taken first and the write second: no overflow is flagged and a word remains held.
- R8: A 32-bit shadow register resets to zero and takes `in_data` on each rise of `in_ack`. On a rise of `out_ack`, bit 10 is set if `out_data` differs from the shadow value held before that edge.
- R9: A violation sampled at one clock edge appears in `err_flags` right after that edge. Error bits stay set until reset, and reset clears all of them.
- R10: No error is recorded while `rst` is high. Inputs sampled during reset become the previous values for the first check after reset, so inputs already high at release give no edge.
- R11: A complete legal write handshake followed by a complete legal read of the same word leaves `err_flags` at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | 1 | Write-port request from the producer |
| in_ack | input | 1 | Write-port acknowledge from the buffer |
| in_data | input | 32 | Write-port data |
| out_req | input | 1 | Read-port request from the buffer |
| out_ack | input | 1 | Read-port acknowledge from the consumer |
| out_data | input | 32 | Read-port data |
| err_flags | output | 11 | Sticky violation bits, layout as in R1-R8 |

## Verification
A wrong held-word state shows up at the next acknowledge rise, which sets a false overflow or underflow bit or misses a real one. A stale or wrongly loaded shadow register shows up only at the next rise of `out_ack`, as a mismatch bit that is wrong. A previous-sample register that is out of step produces false or missing ordering bits one edge after the input change. Because the bits are sticky, any of these errors stays visible at the ports until the next reset.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;
  localparam int NUM_PORTS      = 2;
  localparam int RULES_PER_PORT = 4;
  localparam int RULE_REQ_UP    = 0;
  localparam int RULE_REQ_DN    = 1;
  localparam int RULE_ACK_UP    = 2;
  localparam int RULE_ACK_DN    = 3;
  localparam int OVF_BIT        = NUM_PORTS * RULES_PER_PORT;
  localparam int UNF_BIT        = OVF_BIT + 1;
  localparam int DATA_BIT       = OVF_BIT + 2;
  localparam int NUM_FLAGS      = DATA_BIT + 1;

  typedef struct packed {
    logic req;
    logic ack;
  } hs_pair_t;
endpackage

// File: rtl/hs_edge_track.sv
module hs_edge_track #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic [W-1:0] cur,
  output logic [W-1:0] prev_q
);
  // Loads every edge, reset included, so the first post-reset check has a real history
  always_ff @(posedge clk) begin
    prev_q <= cur;
  end
endmodule

// File: rtl/hs_port_rules.sv
module hs_port_rules
  import hs_mon_pkg::*;
(
  input  logic                      en,
  input  hs_pair_t                  cur,
  input  hs_pair_t                  prev,
  output logic [RULES_PER_PORT-1:0] hit
);
  always_comb begin
    hit = '0;
    if (en) begin
      hit[RULE_REQ_UP] = !prev.req &&  prev.ack &&  cur.req;
      hit[RULE_REQ_DN] =  prev.req && !prev.ack && !cur.req;
      hit[RULE_ACK_UP] = !prev.ack && !prev.req &&  cur.ack;
      hit[RULE_ACK_DN] =  prev.ack &&  prev.req && !cur.ack;
    end
  end
endmodule

// File: rtl/hs_alternation.sv
module hs_alternation (
  input  logic clk,
  input  logic rst,
  input  logic wr_rise,
  input  logic rd_rise,
  output logic ovf_hit,
  output logic unf_hit
);
  logic loaded_q;

  // same-cycle read and write: read consumes first, write refills
  always_comb begin
    ovf_hit = wr_rise && loaded_q && !rd_rise;
    unf_hit = rd_rise && !loaded_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          loaded_q <= 1'b0;
    else if (wr_rise) loaded_q <= 1'b1;
    else if (rd_rise) loaded_q <= 1'b0;
  end

  p_loaded_on_write_r6: assert property (@(posedge clk) disable iff (rst)
    wr_rise |=> loaded_q);
  p_empty_after_read_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_rise && !wr_rise) |=> !loaded_q);
endmodule

// File: rtl/hs_data_shadow.sv
module hs_data_shadow #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_rise,
  input  logic         rd_rise,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] rd_data,
  output logic         mismatch_hit
);
  logic [W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst)          shadow_q <= '0;
    else if (wr_rise) shadow_q <= wr_data;
  end

  assign mismatch_hit = rd_rise && (rd_data != shadow_q);

  p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_rise |=> $stable(shadow_q));
endmodule

// File: rtl/hs_monitor.sv
module hs_monitor
  import hs_mon_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_req,
  input  logic                 in_ack,
  input  logic [DATA_W-1:0]    in_data,
  input  logic                 out_req,
  input  logic                 out_ack,
  input  logic [DATA_W-1:0]    out_data,
  output logic [NUM_FLAGS-1:0] err_flags
);
  localparam int SIG_W = 2 * NUM_PORTS;

  logic [SIG_W-1:0] sig_now;
  logic [SIG_W-1:0] sig_prev;
  logic [NUM_FLAGS-1:0] hit;
  logic [RULES_PER_PORT-1:0] port_hit [NUM_PORTS];
  logic wr_rise, rd_rise;

  assign sig_now = {out_ack, out_req, in_ack, in_req};

  hs_edge_track #(.W(SIG_W)) u_track (
    .clk    (clk),
    .cur    (sig_now),
    .prev_q (sig_prev)
  );

  assign wr_rise = sig_now[1] && !sig_prev[1];
  assign rd_rise = sig_now[3] && !sig_prev[3];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    hs_pair_t cur_p, prev_p;
    assign cur_p  = hs_pair_t'({sig_now[2*p],  sig_now[2*p+1]});
    assign prev_p = hs_pair_t'({sig_prev[2*p], sig_prev[2*p+1]});

    hs_port_rules u_rules (
      .en   (!rst),
      .cur  (cur_p),
      .prev (prev_p),
      .hit  (port_hit[p])
    );
    assign hit[p*RULES_PER_PORT +: RULES_PER_PORT] = port_hit[p];
  end

  hs_alternation u_alt (
    .clk     (clk),
    .rst     (rst),
    .wr_rise (wr_rise),
    .rd_rise (rd_rise),
    .ovf_hit (hit[OVF_BIT]),
    .unf_hit (hit[UNF_BIT])
  );

  hs_data_shadow #(.W(DATA_W)) u_shadow (
    .clk          (clk),
    .rst          (rst),
    .wr_rise      (wr_rise),
    .rd_rise      (rd_rise),
    .wr_data      (in_data),
    .rd_data      (out_data),
    .mismatch_hit (hit[DATA_BIT])
  );

  always_ff @(posedge clk) begin
    if (rst) err_flags <= '0;
    else     err_flags <= err_flags | hit;
  end

  // Port-level properties, written from the handshake rules themselves
  p_wr_req_up_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_req) && $past(in_ack) && in_req) |=> err_flags[0]);
  p_wr_req_dn_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(in_req) && !$past(in_ack) && !in_req) |=> err_flags[1]);
  p_wr_ack_up_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_ack) && !$past(in_req) && in_ack) |=> err_flags[2]);
  p_wr_ack_dn_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(in_ack) && $past(in_req) && !in_ack) |=> err_flags[3]);
  p_rd_req_up_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(out_req) && $past(out_ack) && out_req) |=> err_flags[4]);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sticky
    p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      err_flags[i] |=> err_flags[i]);
  end
endmodule

// File: tb/test_hs_monitor.sv
`timescale 1ns/100ps
module test_hs_monitor;
  localparam real HALF = 2.5;
  localparam int  NV   = 41;
  localparam int  NF   = 11;

  logic clk = 1'b0;
  logic rst, in_req, in_ack, out_req, out_ack;
  logic [31:0] in_data, out_data;
  logic [NF-1:0] err_flags;
  int applied = 0;
  int miscompares = 0;

  always #(HALF) clk = ~clk;

  hs_monitor i_hs_monitor (
    .clk(clk), .rst(rst), .in_req(in_req), .in_ack(in_ack), .in_data(in_data),
    .out_req(out_req), .out_ack(out_ack), .out_data(out_data), .err_flags(err_flags)
  );

  // {rst, in_req, in_ack, out_req, out_ack, in byte, out byte, expected flags}
  localparam logic [31:0] VEC [NV] = '{
    {1'b1, 4'b0000, 8'h00, 8'h00, 11'h000},  // reset
    {1'b1, 4'b0000, 8'h00, 8'h00, 11'h000},
    {1'b0, 4'b1000, 8'hA5, 8'h00, 11'h000},  // R11 legal write
    {1'b0, 4'b1100, 8'hA5, 8'h00, 11'h000},
    {1'b0, 4'b0100, 8'hA5, 8'h00, 11'h000},
    {1'b0, 4'b0000, 8'hA5, 8'h00, 11'h000},
    {1'b0, 4'b0010, 8'hA5, 8'hA5, 11'h000},  // R11 legal read
    {1'b0, 4'b0011, 8'hA5, 8'hA5, 11'h000},
    {1'b0, 4'b0001, 8'hA5, 8'hA5, 11'h000},
    {1'b0, 4'b0000, 8'hA5, 8'hA5, 11'h000},
    {1'b0, 4'b0100, 8'h11, 8'hA5, 11'h004},  // R3 write port
    {1'b0, 4'b1100, 8'h11, 8'hA5, 11'h005},  // R1 write port
    {1'b0, 4'b1000, 8'h11, 8'hA5, 11'h00D},  // R4 write port
    {1'b0, 4'b0000, 8'h11, 8'hA5, 11'h00F},  // R2 write port, R5 read bits clear
    {1'b1, 4'b0000, 8'h00, 8'h00, 11'h000},  // R9 reset clears
    {1'b1, 4'b0001, 8'h00, 8'h00, 11'h000},  // R10 ignored in reset
    {1'b0, 4'b0001, 8'h00, 8'h00, 11'h000},  // R10 no edge at release
    {1'b0, 4'b0000, 8'h00, 8'h00, 11'h000},
    {1'b0, 4'b0010, 8'h00, 8'h00, 11'h000},
    {1'b0, 4'b0011, 8'h00, 8'h00, 11'h200},  // R7 read before any write
    {1'b0, 4'b0001, 8'h00, 8'h00, 11'h200},
    {1'b0, 4'b0000, 8'h00, 8'h00, 11'h200},
    {1'b0, 4'b1000, 8'h22, 8'h00, 11'h200},
    {1'b0, 4'b1100, 8'h22, 8'h00, 11'h200},
    {1'b0, 4'b0100, 8'h22, 8'h00, 11'h200},
    {1'b0, 4'b0000, 8'h22, 8'h00, 11'h200},
    {1'b0, 4'b1000, 8'h33, 8'h00, 11'h200},
    {1'b0, 4'b1100, 8'h33, 8'h00, 11'h300},  // R6 second write
    {1'b0, 4'b0100, 8'h33, 8'h00, 11'h300},
    {1'b0, 4'b0000, 8'h33, 8'h00, 11'h300},
    {1'b0, 4'b0010, 8'h33, 8'h44, 11'h300},
    {1'b0, 4'b0011, 8'h33, 8'h44, 11'h700},  // R8 mismatch
    {1'b0, 4'b0001, 8'h33, 8'h44, 11'h700},
    {1'b0, 4'b0000, 8'h33, 8'h44, 11'h700},
    {1'b0, 4'b0010, 8'h33, 8'h44, 11'h700},
    {1'b0, 4'b0000, 8'h33, 8'h44, 11'h720},  // R2 read port
    {1'b0, 4'b0001, 8'h33, 8'h44, 11'h760},  // R3 read port
    {1'b0, 4'b0011, 8'h33, 8'h44, 11'h770},  // R1 read port
    {1'b0, 4'b0010, 8'h33, 8'h44, 11'h7F0},  // R4 read port
    {1'b0, 4'b0000, 8'h33, 8'h44, 11'h7F0},  // R5 write bits clear
    {1'b0, 4'b0000, 8'h33, 8'h44, 11'h7F0}   // R9 sticky
  };

  task automatic drive(input logic r, input logic [3:0] hs,
                       input logic [31:0] id, input logic [31:0] od);
    @(negedge clk);
    rst = r; {in_req, in_ack, out_req, out_ack} = hs;
    in_data = id; out_data = od;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [NF-1:0] exp, input string req);
    applied++;
    if (err_flags !== exp) begin
      miscompares++;
      $display("FAIL %s: err_flags=%03h expected=%03h", req, err_flags, exp);
    end
  endtask

  initial begin
    rst = 1'b1; {in_req, in_ack, out_req, out_ack} = '0;
    in_data = '0; out_data = '0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][31], VEC[i][30:27], {4{VEC[i][26:19]}}, {4{VEC[i][18:11]}});
      check(VEC[i][10:0], $sformatf("vector %0d (R1..R11 table)", i));
    end

    // R7: simultaneous rises keep a word held
    drive(1, 4'b0000, 0, 0); drive(1, 4'b0000, 0, 0);
    drive(0, 4'b1000, 32'h1234_5678, 0);
    drive(0, 4'b1100, 32'h1234_5678, 0);
    drive(0, 4'b0100, 32'h1234_5678, 0);
    drive(0, 4'b0000, 32'h1234_5678, 0);
    drive(0, 4'b1010, 32'h9ABC_DEF0, 32'h1234_5678);
    drive(0, 4'b1111, 32'h9ABC_DEF0, 32'h1234_5678);
    check(11'h000, "R7 simultaneous rise, R8 old shadow compared");
    drive(0, 4'b0101, 32'h9ABC_DEF0, 32'h1234_5678);
    drive(0, 4'b0000, 32'h9ABC_DEF0, 32'h1234_5678);
    drive(0, 4'b0010, 32'h9ABC_DEF0, 32'h9ABC_DEF0);
    drive(0, 4'b0011, 32'h9ABC_DEF0, 32'h9ABC_DEF0);
    check(11'h000, "R7 word still held after simultaneous rise");
    drive(0, 4'b0001, 0, 0); drive(0, 4'b0000, 0, 0);
    drive(0, 4'b0010, 0, 32'h9ABC_DEF0);
    drive(0, 4'b0011, 0, 32'h9ABC_DEF0);
    check(11'h200, "R7 second read underflows");

    // R8: only the top data bit differs
    drive(1, 4'b0000, 0, 0);
    drive(0, 4'b1000, 0, 0); drive(0, 4'b1100, 0, 0);
    drive(0, 4'b0100, 0, 0); drive(0, 4'b0000, 0, 0);
    drive(0, 4'b0010, 0, 32'h8000_0000);
    drive(0, 4'b0011, 0, 32'h8000_0000);
    check(11'h400, "R8 top-bit mismatch");
    drive(0, 4'b0001, 0, 0); drive(0, 4'b0000, 0, 0);
    for (int k = 0; k < 5; k++) drive(0, 4'b0000, 0, 0);
    check(11'h400, "R9 flag held over idle cycles");
    drive(1, 4'b0000, 0, 0);
    check(11'h000, "R9 reset clears");

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule